// File: doc/BRIEF.md
# Segment Register Load Protection Checker

This block decides whether a protected-mode load of a segment register may go ahead or must fault. A controller pulses `start_i` with the selector, the target class (stack segment or one of the data-segment registers), the current privilege level and the descriptor table limit. The block first looks at the selector alone: is it null, and does its index fall inside the table. Only if the selector passes does it read the descriptor's access-rights byte through a simple request/valid port. It then applies the type, privilege and present checks for the target class, in a fixed order.

Each request ends with a one-cycle `done_o`. With it comes either a commit strobe or a fault code and an error code. A descriptor-valid flag records whether the last committed load installed a usable descriptor. A committed stack-segment load also raises an interrupt-inhibit flag. That flag covers the instruction that follows and drops after the next instruction-completion pulse.

Top module: `seg_load_checker`

## Requirements
- R1: A stack-segment load whose selector is null (values 0x0000 to 0x0003) faults with general protection (fault code 1) and an error code of 0, without a descriptor read.
- R2: A data-segment load with a null selector commits with no fault and no descriptor read, and clears `desc_valid_o`.
- R3: The selector index is bits 15:3 and the RPL is bits 1:0. A non-null load with index*8+7 greater than the table limit faults with general protection, with the full selector as error code, and no descriptor read is made. index*8+7 equal to the limit passes.
- R4: Access-rights bits on `rd_rights_i` (byte bits 7..1): [6] present, [5:4] DPL, [3] segment descriptor, [2] code, [1] conforming, [0] writable/readable. For a stack-segment load the checks run in this order, each failing with general protection and the selector: RPL equals CPL; the descriptor is a segment descriptor, is data, and is writable; DPL equals CPL.
- R5: A stack-segment descriptor that passes R4 but is not present faults with stack fault (code 2) and the selector. A not-present descriptor that also fails R4 reports the R4 fault.
- R6: For a data-segment load, a descriptor that is not a segment descriptor, or is execute-only code, faults with general protection and the selector.
- R7: For a data-segment load of data or nonconforming code, RPL and CPL must both be at most DPL, or the load faults with general protection. Conforming readable code is exempt.
- R8: A data-segment descriptor that passes R6 and R7 but is not present faults with not-present (code 3) and the selector. This check is the last.
- R9: `rd_req_o` rises one cycle after start is taken, carries the selector index on `rd_index_o`, and holds until `rd_valid_i`. `done_o` follows the valid cycle by one cycle. Loads decided without a read finish two cycles after start.
- R10: `done_o` is a one-cycle pulse that carries either `commit_o` (fault code 0) or a nonzero fault code, never both. A committed non-null load sets `desc_valid_o`, and a fault leaves it unchanged.
- R11: A start pulse during a request in progress is ignored and does not change that request's result.
- R12: A committed stack-segment load sets `int_inhibit_o`. It clears after the first `instr_done_i` cycle following the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a segment load check |
| target_ss_i | input | 1 | 1 = stack segment, 0 = data-segment register |
| selector_i | input | 16 | Selector to load |
| cpl_i | input | 2 | Current privilege level |
| table_limit_i | input | LIMIT_W | Descriptor table limit in bytes |
| rd_req_o | output | 1 | Descriptor access-rights read request |
| rd_index_o | output | 13 | Descriptor index being read |
| rd_valid_i | input | 1 | Read data valid |
| rd_rights_i | input | 7 | Access-rights byte bits 7..1 |
| done_o | output | 1 | Request finished (one-cycle pulse) |
| commit_o | output | 1 | Load commits (with done) |
| fault_o | output | 2 | 0 none, 1 general protection, 2 stack fault, 3 not present |
| err_code_o | output | 16 | Fault error code |
| desc_valid_o | output | 1 | Loaded descriptor usable |
| instr_done_i | input | 1 | Instruction-completion pulse |
| int_inhibit_o | output | 1 | Interrupts held off for one instruction |

## Verification
The assertions assume that `rd_valid_i` is raised only while `rd_req_o` is high, and for exactly one cycle per request. They also assume that `instr_done_i` is a single-cycle pulse. The bench's read responder raises valid only after it has seen the request, holds it for one cycle, and then drops it. Instruction completions are pulsed one cycle at a time between loads. All inputs change at the falling clock edge.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  localparam int SEL_W = 16;
  localparam int IDX_W = 13;

  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_GP   = 2'd1,
    FLT_SS   = 2'd2,
    FLT_NP   = 2'd3
  } fault_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PRE   = 2'd1,
    ST_FETCH = 2'd2
  } state_e;

  // access-rights byte bits 7..1
  typedef struct packed {
    logic       present;
    logic [1:0] dpl;
    logic       seg_desc;
    logic       code;
    logic       conf;
    logic       rw;
  } rights_t;

  function automatic logic sel_null(input logic [SEL_W-1:0] s);
    return (s[SEL_W-1:2] == '0);
  endfunction

  function automatic logic stack_type_ok(input rights_t r);
    return r.seg_desc && !r.code && r.rw;
  endfunction

  function automatic logic data_type_ok(input rights_t r);
    return r.seg_desc && (!r.code || r.rw);
  endfunction

  function automatic logic data_priv_applies(input rights_t r);
    return !r.code || !r.conf;
  endfunction

  function automatic logic lvl_le(input logic [1:0] a, input logic [1:0] b);
    return a <= b;
  endfunction
endpackage

// File: rtl/seg_sel_precheck.sv
module seg_sel_precheck
  import seg_chk_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic [SEL_W-1:0]   sel_i,
  input  logic [LIMIT_W-1:0] limit_i,
  input  logic               is_ss_i,
  output logic               null_o,
  output logic               limit_ok_o,
  output fault_e             fault_o
);
  localparam int CMP_W = ((LIMIT_W > SEL_W) ? LIMIT_W : SEL_W) + 1;

  logic [CMP_W-1:0] last_byte;
  logic [CMP_W-1:0] lim_ext;

  always_comb begin
    last_byte  = CMP_W'({sel_i[SEL_W-1:3], 3'b111});
    lim_ext    = CMP_W'(limit_i);
    null_o     = sel_null(sel_i);
    limit_ok_o = (last_byte <= lim_ext);
    if (null_o)           fault_o = is_ss_i ? FLT_GP : FLT_NONE;
    else if (!limit_ok_o) fault_o = FLT_GP;
    else                  fault_o = FLT_NONE;
  end
endmodule

// File: rtl/seg_rights_eval.sv
module seg_rights_eval
  import seg_chk_pkg::*;
(
  input  logic    is_ss_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] cpl_i,
  input  rights_t r_i,
  output logic    type_ok_o,
  output logic    priv_ok_o,
  output fault_e  fault_o
);
  always_comb begin
    if (is_ss_i) begin
      type_ok_o = stack_type_ok(r_i);
      priv_ok_o = (rpl_i == cpl_i) && (r_i.dpl == cpl_i);
      if (rpl_i != cpl_i)           fault_o = FLT_GP;
      else if (!type_ok_o)          fault_o = FLT_GP;
      else if (r_i.dpl != cpl_i)    fault_o = FLT_GP;
      else if (!r_i.present)        fault_o = FLT_SS;
      else                          fault_o = FLT_NONE;
    end else begin
      type_ok_o = data_type_ok(r_i);
      priv_ok_o = !data_priv_applies(r_i) ||
                  (lvl_le(rpl_i, r_i.dpl) && lvl_le(cpl_i, r_i.dpl));
      if (!type_ok_o)               fault_o = FLT_GP;
      else if (!priv_ok_o)          fault_o = FLT_GP;
      else if (!r_i.present)        fault_o = FLT_NP;
      else                          fault_o = FLT_NONE;
    end
  end
endmodule

// File: rtl/seg_inhibit_flag.sv
module seg_inhibit_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end

  // R12
  inh_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_o) |-> $past(set_i));
  // R12
  inh_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(clr_i));
endmodule

// File: rtl/seg_load_checker.sv
module seg_load_checker
  import seg_chk_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               target_ss_i,
  input  logic [15:0]        selector_i,
  input  logic [1:0]         cpl_i,
  input  logic [LIMIT_W-1:0] table_limit_i,
  output logic               rd_req_o,
  output logic [12:0]        rd_index_o,
  input  logic               rd_valid_i,
  input  logic [6:0]         rd_rights_i,
  output logic               done_o,
  output logic               commit_o,
  output logic [1:0]         fault_o,
  output logic [15:0]        err_code_o,
  output logic               desc_valid_o,
  input  logic               instr_done_i,
  output logic               int_inhibit_o
);
  state_e             state;
  logic [SEL_W-1:0]   sel_q;
  logic [1:0]         cpl_q;
  logic               ss_q;
  logic [LIMIT_W-1:0] lim_q;

  logic    pre_null, pre_limit_ok, eval_type_ok, eval_priv_ok;
  fault_e  pre_fault, eval_fault, fin_fault;
  logic    pre_exit, fetch_exit, finish, ss_commit;

  seg_sel_precheck #(.LIMIT_W(LIMIT_W)) u_pre (
    .sel_i      (sel_q),
    .limit_i    (lim_q),
    .is_ss_i    (ss_q),
    .null_o     (pre_null),
    .limit_ok_o (pre_limit_ok),
    .fault_o    (pre_fault)
  );

  seg_rights_eval u_eval (
    .is_ss_i   (ss_q),
    .rpl_i     (sel_q[1:0]),
    .cpl_i     (cpl_q),
    .r_i       (rights_t'(rd_rights_i)),
    .type_ok_o (eval_type_ok),
    .priv_ok_o (eval_priv_ok),
    .fault_o   (eval_fault)
  );

  // named internal events
  assign pre_exit   = (state == ST_PRE) && (pre_null || !pre_limit_ok);
  assign fetch_exit = (state == ST_FETCH) && rd_valid_i;
  assign finish     = pre_exit || fetch_exit;
  assign fin_fault  = pre_exit ? pre_fault : eval_fault;
  assign ss_commit  = finish && (fin_fault == FLT_NONE) && ss_q;

  assign rd_req_o   = (state == ST_FETCH);
  assign rd_index_o = sel_q[SEL_W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      sel_q <= '0;
      cpl_q <= '0;
      ss_q  <= 1'b0;
      lim_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start_i) begin
          sel_q <= selector_i;
          cpl_q <= cpl_i;
          ss_q  <= target_ss_i;
          lim_q <= table_limit_i;
          state <= ST_PRE;
        end
        ST_PRE:   state <= pre_exit ? ST_IDLE : ST_FETCH;
        ST_FETCH: if (rd_valid_i) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_o       <= 1'b0;
      commit_o     <= 1'b0;
      fault_o      <= FLT_NONE;
      err_code_o   <= '0;
      desc_valid_o <= 1'b0;
    end else begin
      done_o   <= finish;
      commit_o <= finish && (fin_fault == FLT_NONE);
      if (finish) begin
        fault_o    <= fin_fault;
        err_code_o <= ((fin_fault == FLT_NONE) || pre_null) ? '0 : sel_q;
        if (fin_fault == FLT_NONE) desc_valid_o <= !pre_null;
      end
    end
  end

  seg_inhibit_flag u_inh (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ss_commit),
    .clr_i  (instr_done_i),
    .flag_o (int_inhibit_o)
  );

  // R10
  commit_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> done_o && (fault_o == FLT_NONE));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R11
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) && start_i |=> $stable(sel_q) && $stable(ss_q));
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o && !rd_valid_i |=> rd_req_o && $stable(rd_index_o));
  // R5
  stack_fault_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (fault_o == FLT_SS) |-> ss_q);
  // R1
  null_err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && (sel_q[SEL_W-1:2] == '0) |-> (err_code_o == '0));
  // R8
  np_data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_exit && (eval_fault == FLT_NP) |-> !ss_q && eval_type_ok && eval_priv_ok);
endmodule

// File: tb/seg_load_checker_tb.sv
module seg_load_checker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        target_ss_i = 1'b0;
  logic [15:0] selector_i = '0;
  logic [1:0]  cpl_i = '0;
  logic [15:0] table_limit_i = '0;
  logic        rd_req_o;
  logic [12:0] rd_index_o;
  logic        rd_valid_i = 1'b0;
  logic [6:0]  rd_rights_i = '0;
  logic        done_o, commit_o, desc_valid_o, int_inhibit_o;
  logic [1:0]  fault_o;
  logic [15:0] err_code_o;
  logic        instr_done_i = 1'b0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit exp_dv = 0;
  bit exp_inh = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  seg_load_checker u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !finished) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 50000);
      summary();
    end
  end

  // behavioural expectation from the requirements
  task automatic predict(input bit ss, input int sel, input int cpl, input int lim,
                         input int ar, output int f, output int e, output bit fetch);
    int idx, rpl, p, dpl, s, c, cf, w;
    idx = sel / 8; rpl = sel % 4;
    fetch = 0; e = 0;
    if (sel < 4) begin f = ss ? 1 : 0; return; end
    if (idx * 8 + 7 > lim) begin f = 1; e = sel; return; end
    fetch = 1;
    p = (ar / 128) % 2; dpl = (ar / 32) % 4; s = (ar / 16) % 2;
    c = (ar / 8) % 2; cf = (ar / 4) % 2; w = (ar / 2) % 2;
    if (ss) begin
      if (rpl != cpl) f = 1;
      else if (!(s == 1 && c == 0 && w == 1)) f = 1;
      else if (dpl != cpl) f = 1;
      else if (p == 0) f = 2;
      else f = 0;
    end else begin
      if (!(s == 1 && (c == 0 || w == 1))) f = 1;
      else if ((c == 0 || cf == 0) && !(rpl <= dpl && cpl <= dpl)) f = 1;
      else if (p == 0) f = 3;
      else f = 0;
    end
    if (f != 0) e = sel;
  endtask

  task automatic outcome(input string req, input int f, input int e, input bit ss, input int sel);
    chk(done_o == 1'b1, {req, " done"}, done_o, 1);
    chk(commit_o == (f == 0), {req, " commit"}, commit_o, (f == 0));
    chk(fault_o == f[1:0], {req, " fault"}, fault_o, f);
    chk(err_code_o == e[15:0], {req, " err"}, err_code_o, e);
    if (f == 0) exp_dv = (sel >= 4);
    if (f == 0 && ss) exp_inh = 1;
    chk(desc_valid_o == exp_dv, {req, " R10 dv"}, desc_valid_o, exp_dv);
    chk(int_inhibit_o == exp_inh, {req, " R12 inh"}, int_inhibit_o, exp_inh);
    @(negedge clk);
    chk(done_o == 1'b0, {req, " R10 pulse"}, done_o, 0);
  endtask

  task automatic do_load(input string req, input bit ss, input int sel, input int cpl,
                         input int lim, input int ar, input int lat, input bit intr);
    int f, e; bit fetch;
    predict(ss, sel, cpl, lim, ar, f, e, fetch);
    @(negedge clk);
    start_i = 1; target_ss_i = ss; selector_i = sel[15:0];
    cpl_i = cpl[1:0]; table_limit_i = lim[15:0];
    @(negedge clk);
    start_i = 0;
    chk(done_o == 0 && rd_req_o == 0, {req, " R9 early"}, done_o, 0);
    @(negedge clk);
    if (!fetch) begin
      chk(rd_req_o == 0, {req, " no read"}, rd_req_o, 0);
      outcome(req, f, e, ss, sel);
    end else begin
      chk(rd_req_o == 1, {req, " R9 req"}, rd_req_o, 1);
      chk(rd_index_o == sel[15:3], {req, " R9 index"}, rd_index_o, sel / 8);
      for (int i = 0; i < lat; i++) begin
        if (intr && i == 0) begin
          start_i = 1; selector_i = 16'hFFF8; target_ss_i = !ss;
        end
        @(negedge clk);
        start_i = 0;
        chk(rd_req_o == 1 && done_o == 0, {req, " R9 wait"}, rd_req_o, 1);
      end
      rd_valid_i = 1; rd_rights_i = ar[7:1];
      @(negedge clk);
      rd_valid_i = 0;
      chk(rd_req_o == 0, {req, " R9 req drop"}, rd_req_o, 0);
      outcome(req, f, e, ss, sel);
    end
  endtask

  task automatic pulse_instr(input string req);
    @(negedge clk); instr_done_i = 1;
    @(negedge clk); instr_done_i = 0;
    exp_inh = 0;
    chk(int_inhibit_o == 0, req, int_inhibit_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(done_o == 0 && commit_o == 0 && fault_o == 0, "reset outputs", done_o, 0);
    chk(desc_valid_o == 0 && int_inhibit_o == 0 && rd_req_o == 0, "reset flags", desc_valid_o, 0);

    do_load("R1 null ss",          1, 'h0002, 2, 'hFF, 'h92, 0, 0);
    do_load("R10 ds ok",           0, 'h0010, 0, 'hFF, 'h92, 1, 0);
    do_load("R2 null ds",          0, 'h0001, 0, 'hFF, 'h92, 0, 0);
    do_load("R10 ds ok again",     0, 'h0010, 0, 'hFF, 'h92, 0, 0);
    do_load("R3 over limit",       0, 'h0100, 0, 'hFF, 'h92, 0, 0);
    do_load("R3 at limit",         0, 'h00F8, 0, 'hFF, 'h92, 0, 0);
    do_load("R3 ss over limit",    1, 'h0100, 0, 'hFF, 'h92, 0, 0);
    do_load("R4 ss rpl",           1, 'h0013, 0, 'hFF, 'h92, 0, 0);
    do_load("R4 ss readonly",      1, 'h0010, 0, 'hFF, 'h90, 0, 0);
    do_load("R4 ss code",          1, 'h0010, 0, 'hFF, 'h9A, 2, 0);
    do_load("R4 ss dpl",           1, 'h0010, 0, 'hFF, 'hF2, 0, 0);
    do_load("R5 ss np+dpl",        1, 'h0010, 0, 'hFF, 'h72, 0, 0);
    do_load("R5 ss np",            1, 'h0010, 0, 'hFF, 'h12, 0, 0);
    do_load("R12 ss ok",           1, 'h001B, 3, 'hFF, 'hF2, 0, 0);
    chk(int_inhibit_o == 1, "R12 held", int_inhibit_o, 1);
    pulse_instr("R12 cleared");
    do_load("R6 system",           0, 'h0010, 0, 'hFF, 'h82, 0, 0);
    do_load("R6 exec only",        0, 'h0010, 0, 'hFF, 'h98, 0, 0);
    do_load("R6 readable code",    0, 'h0010, 0, 'hFF, 'h9A, 0, 0);
    do_load("R7 rpl above dpl",    0, 'h0013, 0, 'hFF, 'hB2, 0, 0);
    do_load("R7 cpl above dpl",    0, 'h0010, 3, 'hFF, 'hD2, 0, 0);
    do_load("R7 conforming",       0, 'h0013, 3, 'hFF, 'h9E, 0, 0);
    do_load("R7 nonconf code",     0, 'h0013, 0, 'hFF, 'h9A, 0, 0);
    do_load("R8 np priv fail",     0, 'h0013, 0, 'hFF, 'h12, 0, 0);
    do_load("R8 np",               0, 'h0013, 0, 'hFF, 'h72, 0, 0);
    do_load("R11 busy start",      0, 'h0023, 1, 'hFF, 'h02, 3, 1);
    do_load("R9 long wait",        1, 'h0028, 0, 'hFFFF, 'h92, 5, 0);
    do_load("R12 ss no clear yet", 1, 'h0030, 0, 'hFF, 'h92, 0, 0);
    chk(int_inhibit_o == 1, "R12 still held", int_inhibit_o, 1);
    pulse_instr("R12 cleared again");
    pulse_instr("R12 stays clear");
    summary();
  end
endmodule